// File: doc/BRIEF.md
# Serial Control Register Slave

This block is a two-wire serial slave that lets a host microcontroller set and read back a bank of 128 byte-wide control registers. The serial clock and serial data are brought in on two separate input pins. Acknowledge and read data leave on a third pin, `ack_o`. Both input lines are oversampled by the much faster system clock through a two-flop synchronizer, and edges are detected in that domain. Start and stop conditions are recognised as data transitions while the serial clock is high. Bytes are shifted MSB first, nine serial clocks to a byte, with the ninth clock reserved for acknowledge.

A write transfer carries the device write address, then a register index, then any number of data bytes. Each data byte is stored at the register pointer, and the pointer then steps up by one and wraps after the top entry. A read takes two transfers. A write transfer loads the pointer and is closed with a stop. A new transfer then opens with the device read address, and the block shifts register contents out inverted on `ack_o`, stepping the pointer after every byte, for as long as the host acknowledges. Acknowledge is an active-high level on `ack_o`. After a received byte it is held until the next rising serial clock, so the host gives one dummy clock before a stop.

The controller has six states:
- IDLE: the bus is free.
- DEV: the device address is being received.
- REG: the register index is being received.
- WDATA: data bytes are being received.
- RDATA: register contents are being transmitted.
- SKIP: the transfer is not addressed to this block, or a read has ended.

The transitions are as follows:
- A start condition moves any state to DEV.
- A stop condition moves any state to IDLE.
- At the eighth bit in DEV, the block moves to REG on the write address, to RDATA on the read address, and to SKIP on any other address.
- At the eighth bit in REG, the block moves to WDATA.
- In RDATA, DATA high at a host acknowledge clock moves the block to SKIP.

Top module: `ssl_ctrl_slave`

## Requirements
- R1: After the active-low reset, `ack_o` is 0, every register reads 0x00 and the pointer is 0x00.
- R2: A start condition (DATA falling while CLK is high) begins device-address reception from bit 0, and `ack_o` is low while the address bits are received. A stop condition (DATA rising while CLK is high) returns the block to idle with `ack_o` low.
- R3: A device address of 0x24 (write) or 0x25 (read) is acknowledged by `ack_o` = 1 while CLK is high in the ninth clock.
- R4: After any other device address, `ack_o` stays 0 and no register changes until the next start condition.
- R5: In a write transfer, the byte after 0x24 loads the pointer from its low 7 bits. Each further byte is stored at the pointer, and the pointer then increments.
- R6: Every byte received in a write transfer is acknowledged with `ack_o` = 1 from the falling CLK edge after its eighth bit. This level is held through the ninth clock and released at the next rising CLK edge (the dummy clock before a stop, or the first bit of the next byte).
- R7: The pointer wraps from 0x7F to 0x00, both when writing and when reading.
- R8: After 0x25 is acknowledged, `ack_o` carries the inverse of the register at the pointer, MSB first. Each bit is presented from a falling CLK edge (the first from the end of the address acknowledge clock). DATA low in a ninth clock requests another byte. DATA high ends the read, and `ack_o` then stays 0.
- R9: In a read transfer, the pointer increments after each byte sent, so consecutive bytes come from consecutive registers.
- R10: A start condition in the middle of a byte discards that byte: a partly received data byte is never written.
- R11: `ack_o` changes only in response to a synchronized CLK edge or a start or stop condition. It is steady while CLK is high during a bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Serial data from the host |
| ack_o | output | 1 | Acknowledge (high) and inverted read data |

## Verification
The bench drives write bursts and read bursts of random length at random register indices, and checks every read byte against a bench-side register model. This separates correct storage and pointer stepping from off-by-one pointer faults and from uninverted or bit-reversed read data. Directed transfers cover three further cases. Bursts that straddle 0x7F expose faulty wrap logic. A foreign device address followed by data, with the target register read back afterwards, shows whether unaddressed traffic is ignored. A start issued after half a data byte shows whether partial bytes are discarded and whether address reception resumes. Acknowledge is sampled in the ninth clock, in the low phase after it, and after the dummy clock, which tells a correct hold-and-release from an early or late release.

// File: rtl/ssl_pkg.sv
package ssl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_REG,
        ST_WDATA,
        ST_RDATA,
        ST_SKIP
    } ssl_state_e;
endpackage

// File: rtl/ssl_line_sync.sv
module ssl_line_sync #(
    parameter int N      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);
    localparam int DEPTH = STAGES + 1;

    for (genvar g = 0; g < N; g++) begin : g_line
        logic [DEPTH-1:0] pipe;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[DEPTH-2:0], line_i[g]};
        end
        assign level_o[g] = pipe[DEPTH-2];
        assign rise_o[g]  = pipe[DEPTH-2] & ~pipe[DEPTH-1];
        assign fall_o[g]  = ~pipe[DEPTH-2] & pipe[DEPTH-1];
    end
endmodule

// File: rtl/ssl_regfile.sv
module ssl_regfile #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/ssl_frame_fsm.sv
module ssl_frame_fsm
    import ssl_pkg::*;
#(
    parameter int          ADDR_W = 7,
    parameter int          DATA_W = 8,
    parameter logic [DATA_W-1:0] DEV_WR = 8'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda,
    input  logic [DATA_W-1:0] rdata,
    output logic              we,
    output logic [ADDR_W-1:0] ptr_o,
    output logic [DATA_W-1:0] wdata,
    output logic              ack_o,
    output ssl_state_e        state_o
);
    localparam int                CNT_W  = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0]  CNT_AK = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0]  CNT_LB = CNT_W'(DATA_W - 1);
    localparam logic [DATA_W-1:0] DEV_RD = DEV_WR | DATA_W'(1);

    ssl_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] shift_q;
    logic [ADDR_W-1:0] ptr_q;
    logic              ack_q, pend_q;
    logic              last_bit, ack_bit;
    logic [DATA_W-1:0] byte_in;

    assign last_bit = (cnt_q == CNT_LB);
    assign ack_bit  = (cnt_q == CNT_AK);
    assign byte_in  = {shift_q[DATA_W-2:0], sda};

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_DEV;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else if (scl_rise) begin
            unique case (state_q)
                ST_DEV: if (last_bit) begin
                    if (byte_in == DEV_WR)      state_d = ST_REG;
                    else if (byte_in == DEV_RD) state_d = ST_RDATA;
                    else                        state_d = ST_SKIP;
                end
                ST_REG:   if (last_bit) state_d = ST_WDATA;
                ST_RDATA: if (ack_bit && !pend_q && sda) state_d = ST_SKIP;
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shift_q <= '0;
            ptr_q   <= '0;
            ack_q   <= 1'b0;
            pend_q  <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q  <= '0;
            ack_q  <= 1'b0;
            pend_q <= 1'b0;
        end else if (scl_rise) begin
            if (ack_bit) begin
                cnt_q  <= '0;
                pend_q <= 1'b0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                if (state_q != ST_RDATA) begin
                    shift_q <= byte_in;
                    if (cnt_q == '0) ack_q <= 1'b0;
                end
                if (last_bit) begin
                    unique case (state_q)
                        ST_DEV:   pend_q <= (byte_in == DEV_WR) || (byte_in == DEV_RD);
                        ST_REG: begin
                            ptr_q  <= byte_in[ADDR_W-1:0];
                            pend_q <= 1'b1;
                        end
                        ST_WDATA: begin
                            ptr_q  <= ptr_q + 1'b1;
                            pend_q <= 1'b1;
                        end
                        ST_RDATA: begin
                            ptr_q  <= ptr_q + 1'b1;
                            pend_q <= 1'b0;
                        end
                        default: pend_q <= 1'b0;
                    endcase
                end
            end
        end else if (scl_fall) begin
            if (state_q == ST_RDATA && cnt_q == '0) begin
                shift_q <= rdata;
                ack_q   <= ~rdata[DATA_W-1];
            end else if (state_q == ST_RDATA && !ack_bit) begin
                ack_q <= ~shift_q[CNT_W'(DATA_W - 1) - cnt_q];
            end else if (ack_bit) begin
                ack_q <= pend_q;
            end
        end
    end

    assign we      = scl_rise && last_bit && (state_q == ST_WDATA) && !start_det && !stop_det;
    assign wdata   = byte_in;
    assign ptr_o   = ptr_q;
    assign ack_o   = ack_q;
    assign state_o = state_q;
endmodule

// File: rtl/ssl_ctrl_slave.sv
module ssl_ctrl_slave
    import ssl_pkg::*;
#(
    parameter int          ADDR_W      = 7,
    parameter int          DATA_W      = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [7:0]  DEV_WR      = 8'h24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic ack_o
);
    logic [1:0]        lvl, rs, fl;
    logic              scl_rise, scl_fall, start_det, stop_det;
    logic              reg_we;
    logic [ADDR_W-1:0] reg_ptr;
    logic [DATA_W-1:0] reg_wdata, reg_rdata;
    ssl_state_e        fsm_state;

    ssl_line_sync #(.N(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  ({sda_i, scl_i}),
        .level_o (lvl),
        .rise_o  (rs),
        .fall_o  (fl)
    );

    assign scl_rise  = rs[0];
    assign scl_fall  = fl[0];
    assign start_det = fl[1] & lvl[0] & ~rs[0];
    assign stop_det  = rs[1] & lvl[0] & ~rs[0];

    ssl_frame_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEV_WR(DATA_W'(DEV_WR))) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda       (lvl[1]),
        .rdata     (reg_rdata),
        .we        (reg_we),
        .ptr_o     (reg_ptr),
        .wdata     (reg_wdata),
        .ack_o     (ack_o),
        .state_o   (fsm_state)
    );

    ssl_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .waddr (reg_ptr),
        .wdata (reg_wdata),
        .raddr (reg_ptr),
        .rdata (reg_rdata)
    );
endmodule

// File: rtl/ssl_ctrl_slave_chk.sv
module ssl_ctrl_slave_chk
    import ssl_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ack_o,
    input logic              start_det,
    input logic              stop_det,
    input logic              scl_rise,
    input logic              scl_fall,
    input logic              we,
    input logic [ADDR_W-1:0] ptr,
    input ssl_state_e        state
);
    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!ack_o && state == ST_IDLE));

    // R2
    start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV && !ack_o));

    // R7
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (ptr == ADDR_W'($past(ptr) + 1'b1)));

    // R4
    skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP) |-> (!ack_o && !we));

    // R11
    ack_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_rise && !scl_fall && !start_det && !stop_det) |=> $stable(ack_o));
endmodule

bind ssl_ctrl_slave ssl_ctrl_slave_chk #(.ADDR_W(ADDR_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_o     (ack_o),
    .start_det (start_det),
    .stop_det  (stop_det),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .we        (reg_we),
    .ptr       (reg_ptr),
    .state     (fsm_state)
);

// File: tb/test_ssl_ctrl_slave.sv
module test_ssl_ctrl_slave;
    localparam int HP = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda = 1'b1;
    logic ack;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [128];

    always #10 clk = ~clk;

    ssl_ctrl_slave i_ssl_ctrl_slave (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_i (scl),
        .sda_i (sda),
        .ack_o (ack)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda = 1'b1; tick(HP);
        scl = 1'b1; tick(HP);
        sda = 1'b0; tick(HP);
        scl = 1'b0; tick(HP);
    endtask

    // enters with scl low; the scl rise is the dummy clock
    task automatic bus_stop(input bit check_release, input string req);
        sda = 1'b0; tick(HP);
        scl = 1'b1; tick(HP/2);
        if (check_release) chk(ack == 1'b0, req, ack, 0);
        tick(HP/2);
        sda = 1'b1; tick(HP);
        chk(ack == 1'b0, "R2", ack, 0);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sda = b[i]; tick(HP);
            scl = 1'b1; tick(HP);
            scl = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda = 1'b1; tick(HP);
        scl = 1'b1; tick(HP/2);
        acked = ack;
        tick(HP/2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input bit more, output logic [7:0] b, output bit steady);
        logic first;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            sda = 1'b1; tick(HP);
            scl = 1'b1; tick(HP/4);
            first = ack;
            tick(HP/4);
            b[i] = ~ack;
            if (ack != first) steady = 1'b0;
            tick(HP/2);
            scl = 1'b0;
        end
        sda = more ? 1'b0 : 1'b1; tick(HP);
        scl = 1'b1; tick(HP);
        scl = 1'b0;
    endtask

    task automatic wr_burst(input logic [6:0] a, input int n, input bit rnd, input logic [7:0] base);
        bit ak;
        logic [7:0] d;
        logic [6:0] p;
        p = a;
        bus_start();
        send_byte(8'h24, ak);
        chk(ak, "R3", ak, 1);
        send_byte({1'b0, a}, ak);
        chk(ak, "R6", ak, 1);
        for (int i = 0; i < n; i++) begin
            d = rnd ? 8'($urandom) : base + 8'(i);
            send_byte(d, ak);
            chk(ak, "R6", ak, 1);
            model[p] = d;
            p = p + 7'd1;
        end
        tick(HP/2);
        chk(ack == 1'b1, "R6", ack, 1);
        bus_stop(1'b1, "R6");
    endtask

    task automatic rd_burst(input logic [6:0] a, input int n, input string req);
        bit ak, st;
        logic [7:0] b;
        logic [6:0] p;
        bus_start();
        send_byte(8'h24, ak);
        send_byte({1'b0, a}, ak);
        bus_stop(1'b0, "R2");
        bus_start();
        send_byte(8'h25, ak);
        chk(ak, "R3", ak, 1);
        p = a;
        for (int i = 0; i < n; i++) begin
            recv_byte(i < n - 1, b, st);
            chk(b == model[p], (i == 0) ? req : "R9", b, model[p]);
            if (i == 0) chk(st, "R11", 0, 1);
            p = p + 7'd1;
        end
        tick(HP/2);
        chk(ack == 1'b0, "R8", ack, 0);
        bus_stop(1'b0, "R8");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        bit ak;
        void'($urandom(32'd19731));
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        tick(5);
        chk(ack == 1'b0, "R1", ack, 0);
        rst_n = 1'b1;
        tick(5);
        chk(ack == 1'b0, "R1", ack, 0);
        rd_burst(7'h00, 2, "R1");
        rd_burst(7'h55, 1, "R1");

        // directed write then read
        wr_burst(7'h10, 4, 1'b0, 8'hA5);
        rd_burst(7'h10, 4, "R5");
        // inversion/MSB order with distinct pattern
        wr_burst(7'h30, 2, 1'b0, 8'h81);
        rd_burst(7'h30, 2, "R8");

        // wrap at top of pointer range
        wr_burst(7'h7E, 4, 1'b0, 8'h3C);
        rd_burst(7'h7F, 3, "R7");

        // foreign device address
        bus_start();
        tick(HP);
        chk(ack == 1'b0, "R2", ack, 0);
        send_byte(8'h48, ak);
        chk(!ak, "R4", ak, 0);
        send_byte(8'h10, ak);
        chk(!ak, "R4", ak, 0);
        send_byte(8'hEE, ak);
        chk(!ak, "R4", ak, 0);
        bus_stop(1'b0, "R4");
        rd_burst(7'h10, 2, "R4");

        // start in the middle of a data byte
        bus_start();
        send_byte(8'h24, ak);
        send_byte(8'h20, ak);
        send_bits(8'hC3, 4);
        bus_start();
        send_byte(8'h24, ak);
        chk(ak, "R10", ak, 1);
        send_byte(8'h21, ak);
        send_byte(8'h5A, ak);
        model[7'h21] = 8'h5A;
        bus_stop(1'b1, "R6");
        rd_burst(7'h20, 2, "R10");

        // random traffic
        for (int k = 0; k < 14; k++) begin
            logic [6:0] a;
            a = 7'($urandom);
            if ($urandom % 2 == 0) wr_burst(a, 1 + int'($urandom % 6), 1'b1, 8'h00);
            else                   rd_burst(a, 1 + int'($urandom % 5), "R5");
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule